// File: doc/BRIEF.md
# Dual-Domain Software Event Generator

This block lets software raise one event that can interrupt the host, the core, or both. The host side holds a software event flag. It drives the host interrupt when the matching host enable bit is also set. The core side holds its own event flag. That flag is set only at the moment the host flag goes from 0 to 1, and it drives the core interrupt through a separate core enable bit.

A mode bit, written from the core port, chooses how the host flag reacts when a 1 is written to it:
- **Toggle mode (mode 0):** a 1 flips the host flag.
- **Set-only mode (mode 1):** a 1 can only set the host flag. The host flag is then cleared as a side effect when the core clears its own flag.

The core can also raise the event by writing the host flag through its own port.

The host flag is held by a two-state machine with states `HS_IDLE` (flag 0) and `HS_ACTIVE` (flag 1). Its named transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| `T_SET` | `HS_IDLE` | `HS_ACTIVE` | An effective write of 1 reaches the host flag. |
| `T_TOGGLE_CLR` | `HS_ACTIVE` | `HS_IDLE` | Mode 0, and an effective write of 1 reaches the host flag. |
| `T_CORE_CLR` | `HS_ACTIVE` | `HS_IDLE` | Mode 1, and the core writes 1 to clear its own flag. |

In every other case the machine stays where it is. `T_SET` is the rising transition, and it is what sets the core flag.

Top module: `swe_event_gen`

## Requirements
- R1: `irq_host` is 1 exactly when both the host event flag and the host enable bit are 1. Clearing the enable bit leaves the flag unchanged.
- R2: `irq_core` is 1 exactly when both the core event flag and the core enable bit are 1.
- R3: A host write to host address 0 with data bit 6 = 1, while the host flag is 0, sets the host flag. The flag is visible one clock after the write.
- R4: The core flag is set in the same cycle that the host flag goes from 0 to 1. It is never set while the host flag merely stays at 1.
- R5: In mode 0, a write of 1 to the host flag while the flag is 1 clears it.
- R6: A core write to core address 0 with data bit 6 = 1 clears the core flag. Data bit 6 = 0 leaves the flag unchanged. If the core flag is being set in the same cycle, the set wins.
- R7: A core write to core address 3 with data bit 6 = 1 acts on the host flag exactly as a host write of 1 does. This includes setting the core flag on the rising edge.
- R8: In mode 1, a write of 1 to a host flag that is already 1 leaves it at 1. A core clear of the core flag also clears the host flag.
- R9: Writing 0 to data bit 6 of the host flag never changes it, in either mode.
- R10: When the host writes host address 0 in the same cycle that the core writes core address 3, only the host data takes effect.
- R11: After reset, both flags, both enable bits and the mode bit are 0, and both interrupts are 0.
- R12: Register layout:
  - The host port reads the host flag at address 0, bit 6, and the host enable at address 1, bit 6.
  - The core port reads the core flag (address 0, bit 6), the core enable (address 1, bit 6), the mode (address 2, bit 0) and the host flag (address 3, bit 6).
  - All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 1 | Host register address (0 flag, 1 enable) |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data for `h_addr` |
| c_we | input | 1 | Core write strobe |
| c_addr | input | 2 | Core register address (0 flag, 1 enable, 2 mode, 3 host flag) |
| c_wdata | input | 8 | Core write data |
| c_rdata | output | 8 | Core read data for `c_addr` |
| irq_host | output | 1 | Host interrupt |
| irq_core | output | 1 | Core interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, the event at bit 6 and the mode at bit 0. With these values every register bit can be driven and read back through the two ports. This lets the bench walk both modes through `T_SET`, `T_TOGGLE_CLR` and `T_CORE_CLR`. It also exercises the level-versus-edge distinction for the core flag, and both orderings of data on simultaneous host and core writes, with all results observed at the outputs.

// File: rtl/swe_pkg.sv
package swe_pkg;
    localparam int HADDR_W = 1;
    localparam int CADDR_W = 2;

    localparam logic [HADDR_W-1:0] HA_FLAG = 1'd0;
    localparam logic [HADDR_W-1:0] HA_EN   = 1'd1;

    localparam logic [CADDR_W-1:0] CA_FLAG  = 2'd0;
    localparam logic [CADDR_W-1:0] CA_EN    = 2'd1;
    localparam logic [CADDR_W-1:0] CA_MODE  = 2'd2;
    localparam logic [CADDR_W-1:0] CA_HFLAG = 2'd3;

    typedef enum logic [0:0] {
        HS_IDLE   = 1'b0,
        HS_ACTIVE = 1'b1
    } host_state_t;
endpackage

// File: rtl/swe_host_fsm.sv
module swe_host_fsm
    import swe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_setonly,
    input  logic wr_one,
    input  logic core_clr,
    output logic evt,
    output logic rise
);
    host_state_t state_q;
    host_state_t state_d;

    // Next-state logic: the three named transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: begin
                if (wr_one) begin
                    state_d = HS_ACTIVE;               // T_SET
                end
            end
            HS_ACTIVE: begin
                if (!mode_setonly && wr_one) begin
                    state_d = HS_IDLE;                 // T_TOGGLE_CLR
                end else if (mode_setonly && core_clr) begin
                    state_d = HS_IDLE;                 // T_CORE_CLR
                end
            end
            default: state_d = HS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        evt  = (state_q == HS_ACTIVE);
        rise = (state_q == HS_IDLE) && (state_d == HS_ACTIVE);
    end
endmodule

// File: rtl/swe_core_flag.sv
module swe_core_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_edge,
    input  logic clr_w1c,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_edge) begin
            flag <= 1'b1;
        end else if (clr_w1c) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/swe_event_gen.sv
module swe_event_gen
    import swe_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int EVT_BIT  = 6,
    parameter int MODE_BIT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_we,
    input  logic [HADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic [DATA_W-1:0]  h_rdata,
    input  logic               c_we,
    input  logic [CADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0]  c_wdata,
    output logic [DATA_W-1:0]  c_rdata,
    output logic               irq_host,
    output logic               irq_core
);
    logic host_hit;
    logic core_hit;
    logic wr_one;
    logic core_clr;
    logic host_evt;
    logic host_rise;
    logic core_evt;
    logic host_en;
    logic core_en;
    logic mode_q;
    logic unused_wdata;

    // Host write to the host flag wins over the core's path to it (R10).
    assign host_hit = h_we && (h_addr == HA_FLAG);
    assign core_hit = c_we && (c_addr == CA_HFLAG);
    assign wr_one   = host_hit ? h_wdata[EVT_BIT] : (core_hit && c_wdata[EVT_BIT]);
    assign core_clr = c_we && (c_addr == CA_FLAG) && c_wdata[EVT_BIT];

    swe_host_fsm u_host_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_setonly (mode_q),
        .wr_one       (wr_one),
        .core_clr     (core_clr),
        .evt          (host_evt),
        .rise         (host_rise)
    );

    swe_core_flag u_core_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_edge (host_rise),
        .clr_w1c  (core_clr),
        .flag     (core_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_en <= 1'b0;
            core_en <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            if (h_we && (h_addr == HA_EN)) begin
                host_en <= h_wdata[EVT_BIT];
            end
            if (c_we && (c_addr == CA_EN)) begin
                core_en <= c_wdata[EVT_BIT];
            end
            if (c_we && (c_addr == CA_MODE)) begin
                mode_q <= c_wdata[MODE_BIT];
            end
        end
    end

    always_comb begin
        h_rdata = '0;
        unique case (h_addr)
            HA_FLAG: h_rdata[EVT_BIT] = host_evt;
            HA_EN:   h_rdata[EVT_BIT] = host_en;
            default: h_rdata = '0;
        endcase
    end

    always_comb begin
        c_rdata = '0;
        unique case (c_addr)
            CA_FLAG:  c_rdata[EVT_BIT]  = core_evt;
            CA_EN:    c_rdata[EVT_BIT]  = core_en;
            CA_MODE:  c_rdata[MODE_BIT] = mode_q;
            CA_HFLAG: c_rdata[EVT_BIT]  = host_evt;
            default:  c_rdata = '0;
        endcase
    end

    assign irq_host = host_evt && host_en;
    assign irq_core = core_evt && core_en;

    assign unused_wdata = ^{h_wdata, c_wdata};
endmodule

// File: rtl/swe_event_gen_chk.sv
module swe_event_gen_chk
    import swe_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int EVT_BIT  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               h_we,
    input logic [HADDR_W-1:0] h_addr,
    input logic [DATA_W-1:0]  h_wdata,
    input logic               c_we,
    input logic [CADDR_W-1:0] c_addr,
    input logic [DATA_W-1:0]  c_wdata,
    input logic               host_evt,
    input logic               core_evt,
    input logic               core_en,
    input logic               mode_q,
    input logic               irq_core
);
    logic h_one;
    logic h_zero;
    logic c_clr;
    assign h_one  = h_we && (h_addr == HA_FLAG) && h_wdata[EVT_BIT];
    assign h_zero = h_we && (h_addr == HA_FLAG) && !h_wdata[EVT_BIT];
    assign c_clr  = c_we && (c_addr == CA_FLAG) && c_wdata[EVT_BIT];

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_one && !host_evt) |=> host_evt);

    p_rise_sets_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_evt) |-> core_evt);

    p_core_only_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_evt) |-> $rose(host_evt));

    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && host_evt && h_one) |=> !host_evt);

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_evt && host_evt && c_clr) |=> !core_evt);

    p_setonly_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && host_evt && !c_clr) |=> host_evt);

    p_write_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_zero && !(mode_q && host_evt && c_clr)) |=> $stable(host_evt));

    p_core_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_core |-> (core_evt && core_en));
endmodule

bind swe_event_gen swe_event_gen_chk #(
    .DATA_W  (DATA_W),
    .EVT_BIT (EVT_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_we     (h_we),
    .h_addr   (h_addr),
    .h_wdata  (h_wdata),
    .c_we     (c_we),
    .c_addr   (c_addr),
    .c_wdata  (c_wdata),
    .host_evt (host_evt),
    .core_evt (core_evt),
    .core_en  (core_en),
    .mode_q   (mode_q),
    .irq_core (irq_core)
);

// File: tb/swe_event_gen_test.sv
`timescale 1ns/1ps
module swe_event_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_we = 1'b0;
    logic [0:0] h_addr = '0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic       c_we = 1'b0;
    logic [1:0] c_addr = '0;
    logic [7:0] c_wdata = '0;
    logic [7:0] c_rdata;
    logic       irq_host;
    logic       irq_core;

    always #2.5 clk = ~clk;

    swe_event_gen uut (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .irq_host(irq_host), .irq_core(irq_core)
    );

    typedef struct {
        string      tag;
        logic       hirq;
        logic       cirq;
        logic [7:0] hrd;
        logic [7:0] crd;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // Bench model of the register state, built from the requirements.
    logic m_hs = 0, m_he = 0, m_cs = 0, m_ce = 0, m_mode = 0;

    task automatic step(input logic hwe, input logic [0:0] ha, input logic [7:0] hd,
                        input logic cwe, input logic [1:0] ca, input logic [7:0] cd,
                        input logic [0:0] ph, input logic [1:0] pc, input string tag);
        logic req, cclr, n_hs, n_cs, rise;
        exp_t e;
        @(negedge clk); #1;
        h_we = hwe; h_addr = ha; h_wdata = hd;
        c_we = cwe; c_addr = ca; c_wdata = cd;
        if (hwe && ha == 1'b0)      req = hd[6];
        else if (cwe && ca == 2'd3) req = cd[6];
        else                        req = 1'b0;
        cclr = cwe && ca == 2'd0 && cd[6];
        if (!m_hs)       n_hs = req;
        else if (!m_mode) n_hs = !req;
        else              n_hs = !cclr;
        rise = !m_hs && n_hs;
        n_cs = rise ? 1'b1 : (cclr ? 1'b0 : m_cs);
        if (hwe && ha == 1'b1) m_he = hd[6];
        if (cwe && ca == 2'd1) m_ce = cd[6];
        if (cwe && ca == 2'd2) m_mode = cd[0];
        m_hs = n_hs;
        m_cs = n_cs;
        @(posedge clk); #1;
        h_we = 1'b0; c_we = 1'b0; h_wdata = '0; c_wdata = '0;
        h_addr = ph; c_addr = pc;
        e.tag  = tag;
        e.hirq = m_hs && m_he;
        e.cirq = m_cs && m_ce;
        e.hrd  = (ph == 1'b0) ? {1'b0, m_hs, 6'b0} : {1'b0, m_he, 6'b0};
        case (pc)
            2'd0:    e.crd = {1'b0, m_cs, 6'b0};
            2'd1:    e.crd = {1'b0, m_ce, 6'b0};
            2'd2:    e.crd = {7'b0, m_mode};
            default: e.crd = {1'b0, m_hs, 6'b0};
        endcase
        expq.push_back(e);
    endtask

    // Monitor: compares each expected item at the following falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (irq_host !== e.hirq || irq_core !== e.cirq ||
                    h_rdata !== e.hrd || c_rdata !== e.crd) begin
                    errors++;
                    $display("FAIL %s: irq_host=%b irq_core=%b h_rdata=%h c_rdata=%h expected %b %b %h %h",
                             e.tag, irq_host, irq_core, h_rdata, c_rdata,
                             e.hirq, e.cirq, e.hrd, e.crd);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        if (!done) begin
            repeat (5000) @(posedge clk);
            if (!done) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=finished");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset values, peeking enable and mode
        step(0, 0, 8'h00, 0, 0, 8'h00, 1, 2, "R11 reset enable/mode");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R11 reset flags");
        // R12: enables, other bits read 0
        step(1, 1, 8'hFF, 0, 0, 8'h00, 1, 1, "R12 host enable readback");
        step(0, 0, 8'h00, 1, 1, 8'h40, 0, 1, "R12 core enable readback");
        // R9: write 0 does nothing
        step(1, 0, 8'hBF, 0, 0, 8'h00, 0, 0, "R9 write zero mode0");
        // R3, R4, R1, R2: set event
        step(1, 0, 8'h40, 0, 0, 8'h00, 0, 0, "R3 R4 R1 R2 host set");
        // R6: core write 0 no effect
        step(0, 0, 8'h00, 1, 0, 8'hBF, 0, 3, "R6 core write zero");
        step(0, 0, 8'h00, 1, 0, 8'h40, 0, 0, "R6 core w1c");
        // R4: host stays 1, core flag not set again
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R4 level does not set");
        // R5: toggle clears
        step(1, 0, 8'h40, 0, 0, 8'h00, 0, 0, "R5 toggle clear");
        // R1: enable off masks host irq
        step(1, 1, 8'h00, 0, 0, 8'h00, 0, 0, "R1 host enable off");
        step(1, 0, 8'h40, 0, 0, 8'h00, 0, 0, "R1 flag set enable off");
        step(1, 1, 8'h40, 0, 0, 8'h00, 0, 0, "R1 enable on again");
        step(0, 0, 8'h00, 1, 1, 8'h00, 0, 0, "R2 core enable off");
        step(0, 0, 8'h00, 1, 1, 8'h40, 0, 0, "R2 core enable on");
        step(1, 0, 8'h40, 1, 0, 8'h40, 0, 0, "R5 R6 toggle and w1c");
        // R7: core path sets the host flag
        step(0, 0, 8'h00, 1, 3, 8'h40, 0, 3, "R7 core sets host flag");
        step(0, 0, 8'h00, 1, 3, 8'h40, 0, 0, "R7 core toggles host flag");
        step(0, 0, 8'h00, 1, 0, 8'h40, 0, 0, "R6 clear core flag");
        // R12 and R8: set-only mode
        step(0, 0, 8'h00, 1, 2, 8'hFF, 0, 2, "R12 mode readback");
        step(1, 0, 8'h40, 0, 0, 8'h00, 0, 0, "R8 host set mode1");
        step(1, 0, 8'h40, 0, 0, 8'h00, 0, 0, "R8 write one holds");
        step(0, 0, 8'h00, 1, 3, 8'h40, 0, 3, "R8 core path holds");
        step(1, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R9 write zero mode1");
        step(0, 0, 8'h00, 1, 0, 8'h40, 0, 3, "R8 core clear clears host");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R8 both flags clear");
        // R10: simultaneous host and core writes
        step(1, 0, 8'h00, 1, 3, 8'h40, 0, 0, "R10 host zero wins");
        step(1, 0, 8'h40, 1, 3, 8'h00, 0, 0, "R10 host one wins");
        step(1, 1, 8'h40, 1, 3, 8'h40, 0, 0, "R10 core applies when host writes enable");
        // Back to mode 0 and clear
        step(0, 0, 8'h00, 1, 2, 8'h00, 0, 2, "R12 mode zero");
        step(1, 0, 8'h40, 1, 0, 8'h40, 0, 0, "R5 final toggle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule